// File: doc/BRIEF.md
# Flash-Clearable Separate-Port SRAM

A synchronous memory of 1024 words by 4 bits with a dedicated data-in port and a dedicated data-out port. Four active-low controls (select, output enable, write enable and clear) pick one of six modes each cycle. Reads are registered and deliver the addressed word one cycle after the request. Writes store the input word and keep the output released.

A bulk clear zeroes the whole array at once: one clear command drops a per-word valid flag for every location in a single edge, so every word then reads as zero and no sweep through the addresses is ever visible. A busy flag covers the two cycles after a clear command, and read or write requests sampled during that window are dropped. The tri-state output is modelled as a data bus plus an enable flag, where a low enable stands for high impedance and the bus is held at zero.

Top module: `flashclr_sram`

## Requirements
- R1: With sel_n high, no read and no write occurs: the next cycle has dout_en low and the stored words are unchanged.
- R2: A read (sel_n low, clr_n high, we_n high, oe_n low, busy low) gives dout_en high and dout equal to the addressed word on the next cycle; a word not written since the last clear or reset reads as zero.
- R3: A write (sel_n low, clr_n high, we_n low, busy low) stores din at addr whatever oe_n is, gives dout_en low on the next cycle, and a read of that address issued in the following cycle returns the new word.
- R4: With sel_n low, clr_n high, we_n high and oe_n high, the next cycle has dout_en low and nothing is stored.
- R5: A clear command (sel_n low, clr_n low, we_n high) makes every word read as zero, and the next cycle has dout_en low; the first read once busy is low returns zero.
- R6: After a clear command, busy is high for exactly the two following cycles; read and write requests sampled while busy is high are ignored (dout_en low next cycle, nothing stored).
- R7: clr_n low together with we_n low is no operation: no clear, no write, dout_en low next cycle.
- R8: Whenever dout_en is low, dout is all zero.
- R9: After rst_n is released, busy and dout_en are low and every word reads as zero.
- R10: A clear command accepted while busy is high restarts the two-cycle busy window from that command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 10 | Word address |
| din | input | 4 | Write data |
| sel_n | input | 1 | Active-low select |
| clr_n | input | 1 | Active-low bulk clear request |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| dout | output | 4 | Read data, zero when released |
| dout_en | output | 1 | High when dout is driven (low stands for high impedance) |
| busy | output | 1 | High during the two cycles after a clear command |

## Verification
The two functions that meet in one cycle are the ending clear window and a fresh access: a read or write arriving on the last busy cycle must be dropped, while the same request one cycle later must be served and must see the cleared array. The bench provokes this by issuing a clear and then reads and writes on each of the following cycles, and by issuing a second clear inside the window; a bench model that tracks the busy count and the word contents independently judges every output, busy and dout_en value cycle by cycle, along with thousands of random cycles in which clears land among reads and writes to a small set of hot addresses.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;
endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
  import fcs_pkg::*;
(
  input  logic sel_n,
  input  logic clr_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic busy,
  output op_e  op
);
  always_comb begin
    op = OP_NONE;
    if (!sel_n) begin
      if (!clr_n) begin
        // clear only with write enable released; clr with we low is a no-op
        if (we_n) op = OP_CLEAR;
      end else if (!busy) begin
        if (!we_n)      op = OP_WRITE;
        else if (!oe_n) op = OP_READ;
      end
    end
  end
endmodule

// File: rtl/fcs_clear_seq.sv
module fcs_clear_seq #(
  parameter int CLR_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CLR_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = CW'(CLR_CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/fcs_valid_bits.sv
module fcs_valid_bits #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          set,
  input  logic [AW-1:0] addr,
  output logic          rd_valid
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (clr)      vld_d = '0;
    else if (set) vld_d[addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign rd_valid = vld_q[addr];
endmodule

// File: rtl/fcs_store.sv
module fcs_store #(
  parameter int AW = 10,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rword
);
  localparam int DEPTH = 1 << AW;

  // one storage plane per data bit
  for (genvar b = 0; b < DW; b++) begin : g_plane
    logic [DEPTH-1:0] plane_q;
    always_ff @(posedge clk) begin
      if (wr_en) plane_q[addr] <= din[b];
    end
    assign rword[b] = plane_q[addr];
  end
endmodule

// File: rtl/flashclr_sram.sv
module flashclr_sram
  import fcs_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 4,
  parameter int CLR_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              sel_n,
  input  logic              clr_n,
  input  logic              oe_n,
  input  logic              we_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy
);
  op_e              op;
  logic             rd_valid;
  logic [DATA_W-1:0] rword;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic             en_q, en_d;

  fcs_decode u_dec (
    .sel_n (sel_n),
    .clr_n (clr_n),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .busy  (busy),
    .op    (op)
  );

  fcs_clear_seq #(.CLR_CYCLES(CLR_CYCLES)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (op == OP_CLEAR),
    .busy  (busy)
  );

  fcs_valid_bits #(.AW(ADDR_W)) u_vld (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (op == OP_CLEAR),
    .set      (op == OP_WRITE),
    .addr     (addr),
    .rd_valid (rd_valid)
  );

  fcs_store #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk   (clk),
    .wr_en (op == OP_WRITE),
    .addr  (addr),
    .din   (din),
    .rword (rword)
  );

  always_comb begin
    en_d    = (op == OP_READ);
    rdata_d = '0;
    if (op == OP_READ && rd_valid) rdata_d = rword;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      en_q    <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      en_q    <= en_d;
    end
  end

  assign dout    = rdata_q;
  assign dout_en = en_q;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              clr_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              busy
);
  assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !dout_en);

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && clr_n && we_n && !oe_n && !busy) |=> dout_en);

  assert_write_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && clr_n && !we_n) |=> !dout_en);

  assert_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && clr_n && we_n && oe_n) |=> !dout_en);

  assert_clear_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !clr_n && we_n) |=> (busy && !dout_en));

  assert_busy_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  assert_busy_drops_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sel_n && clr_n && we_n && !oe_n) |=> !dout_en);

  assert_clr_we_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !clr_n && !we_n && !busy) |=> (!dout_en && !busy));

  assert_zero_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));
endmodule

bind flashclr_sram fcs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel_n   (sel_n),
  .clr_n   (clr_n),
  .oe_n    (oe_n),
  .we_n    (we_n),
  .dout    (dout),
  .dout_en (dout_en),
  .busy    (busy)
);

// File: tb/sim_flashclr_sram.sv
module sim_flashclr_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 4;
  localparam int NWORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          sel_n = 1'b1, clr_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [DW-1:0] dout;
  logic          dout_en, busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [DW-1:0] mdl_mem [NWORDS];
  int            mdl_bcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flashclr_sram u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .sel_n(sel_n), .clr_n(clr_n), .oe_n(oe_n), .we_n(we_n),
    .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive after falling edge, sample after the next falling edge
  task automatic step(int a, int d, bit sn, bit cn, bit on, bit wn, string tag_in);
    string tag;
    int    exp_en, exp_d;
    bit    mbusy;
    tag   = tag_in;
    mbusy = (mdl_bcnt != 0);
    addr = AW'(a); din = DW'(d);
    sel_n = sn; clr_n = cn; oe_n = on; we_n = wn;
    exp_en = 0; exp_d = 0;
    if (sn) begin
      if (tag == "") tag = "R1";
      if (mdl_bcnt > 0) mdl_bcnt--;
    end else if (!cn && wn) begin
      if (tag == "") tag = "R5";
      for (int i = 0; i < NWORDS; i++) mdl_mem[i] = '0;
      mdl_bcnt = 2;
    end else begin
      if (mdl_bcnt > 0) mdl_bcnt--;
      if (!cn) begin
        if (tag == "") tag = "R7";
      end else if (mbusy) begin
        if (tag == "") tag = "R6";
      end else if (!wn) begin
        if (tag == "") tag = "R3";
        mdl_mem[a] = DW'(d);
      end else if (!on) begin
        if (tag == "") tag = "R2";
        exp_en = 1; exp_d = int'(mdl_mem[a]);
      end else begin
        if (tag == "") tag = "R4";
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "dout_en", int'(dout_en), exp_en);
    check(exp_en != 0 ? tag : "R8", "dout", int'(dout), exp_d);
    check(tag_in == "R10" ? "R10" : "R6", "busy", int'(busy), int'(mdl_bcnt != 0));
  endtask

  task automatic rd(int a, string tag);  step(a, 0, 0, 1, 0, 1, tag); endtask
  task automatic wr(int a, int d);       step(a, d, 0, 1, 1, 0, "");  endtask
  task automatic clr(string tag);        step(0, 0, 0, 0, 1, 1, tag); endtask

  initial begin
    int r;
    for (int i = 0; i < NWORDS; i++) mdl_mem[i] = '0;
    void'($urandom(32'h5eed_c1a0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9", "busy", int'(busy), 0);
    check("R9", "dout_en", int'(dout_en), 0);
    check("R9", "dout", int'(dout), 0);
    rd(5, "R9");
    rd(1023, "R9");
    // R3: write then read back, oe_n ignored on write
    wr(5, 4'hA);
    rd(5, "R3");
    step(6, 3, 0, 1, 0, 0, "R3");
    rd(6, "R3");
    step(1023, 9, 0, 1, 1, 0, "");
    rd(1023, "R2");
    // R1: deselected write attempt leaves word
    step(5, 4'hF, 1, 1, 0, 0, "R1");
    rd(5, "R1");
    // R4: output disabled
    step(5, 0, 0, 1, 1, 1, "R4");
    // R7: clear with write enable low is a no-op
    step(5, 0, 0, 0, 0, 0, "R7");
    rd(5, "R7");
    // R5/R6: clear, accesses in the window dropped, then zero read
    clr("R5");
    rd(5, "R6");
    step(6, 7, 0, 1, 0, 0, "R6");
    rd(5, "R5");
    rd(6, "R5");
    rd(1023, "R5");
    // R10: second clear restarts the window
    wr(9, 4'h6);
    clr("R10");
    clr("R10");
    rd(9, "R10");
    step(9, 2, 0, 1, 0, 0, "R10");
    rd(9, "R10");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int a, d, k;
      k = int'($urandom_range(99));
      a = (k % 7 == 0) ? int'($urandom_range(NWORDS - 1)) : int'($urandom_range(15));
      d = int'($urandom_range(15));
      r = int'($urandom_range(99));
      if (r < 4)       clr("");
      else if (r < 8)  step(a, d, 0, 0, $urandom_range(1), 0, "");
      else if (r < 16) step(a, d, 1, $urandom_range(1), $urandom_range(1), $urandom_range(1), "");
      else if (r < 22) step(a, d, 0, 1, 1, 1, "");
      else if (r < 55) step(a, d, 0, 1, $urandom_range(1), 0, "");
      else             rd(a, "");
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule